// File: doc/BRIEF.md
# Dual-Buffer Transmit Command Controller

This block is the transmit side of a small Ethernet MAC. It is reached over a 32-bit register bus and holds two packet buffers. Bit 11 of the byte address picks the buffer. Each buffer has three word registers: a frame length, a global interrupt enable and a control word. Software fills a buffer through the bus and then writes its control word.

The control write has two possible effects. With bits 1:0 = `01` it sends the frame: the block announces it with a start pulse and the length, then streams the buffer bytes over a valid/ready handshake. With bits 1:0 = `11` it loads the 48-bit station address from the first six bytes of the buffer. Both banks share one engine. A start on one bank while the other bank is running waits, then runs after it. The run bits clear themselves when the work is done. The completion interrupt is allowed only by the global enable of buffer 0.

Top module: `mac_tx_cmd`

## Requirements
- R1: After reset, every register reads 0, `irq`, `fo_valid`, `fo_start` and `fo_done` are low, and `station_addr` equals the parameter `STATION_RST`.
- R2: Register map, per bank: length at byte offset 0x7F4 (low 11 bits kept), global enable at 0x7F8 (only bit 31 kept), control at 0x7FC. Bank 1 adds 0x800 to these offsets. Read data appears on `bus_rdata` the cycle after the read is taken. Any address that is not a register reads 0.
- R3: A write below byte offset 0x7E4 within a bank stores one buffer word. Buffer byte k sits in word k/4 at bits 8*(k%4)+7 down to 8*(k%4).
- R4: A control write with bit0=1 and bit1=0 sends a frame. `fo_start` pulses once with `fo_len` equal to the length register, capped at 0x7E4. The buffer bytes then follow in order, and `fo_last` marks the final byte. `fo_done` pulses after the frame. A length of 0 gives a start pulse and a done pulse with no bytes.
- R5: A control write with bit0=1 and bit1=1 produces no frame. It sets `station_addr[47:40]` to buffer byte 0, and so on down to `[7:0]` = byte 5.
- R6: While an operation is pending or running, control bits 1:0 read as written. When it completes they clear to 0, and all other control bits keep their written value.
- R7: A control write with bit0=0 starts nothing. It stores the value with bits 1:0 cleared.
- R8: A control write to a bank whose bit0 is still set is ignored completely.
- R9: When an operation completes, `irq` goes high for exactly one cycle, one cycle after completion. This happens only if control bit 3 of that bank is set and bit 31 of bank 0's global enable is set. Bank 1's global enable has no effect.
- R10: A start on one bank while the other bank is running is kept and served after the running operation.
- R11: While `fo_valid` is high and `fo_ready` is low, `fo_valid` and `fo_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| fo_start | output | 1 | Frame announce pulse |
| fo_len | output | 11 | Frame length, valid with `fo_start` |
| fo_valid | output | 1 | Frame byte valid |
| fo_ready | input | 1 | Frame byte accepted |
| fo_data | output | 8 | Frame byte |
| fo_last | output | 1 | Final byte of the frame |
| fo_done | output | 1 | Frame complete pulse |
| station_addr | output | 48 | Programmed station address |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The hardest state to reach from the ports is a control write that arrives while the same bank is still busy. The same goes for a start on the other bank that arrives during a running frame. Zero-cycle operations finish before the bus can act again. The bench therefore holds `fo_ready` low, which stalls the engine on the first byte of a frame. It then reads back the busy bits, issues the ignored write and queues the second bank. After that it releases the stream and checks the order of the bytes. It also uses a length above the buffer size to reach the cap.

// File: rtl/mac_tx_pkg.sv
package mac_tx_pkg;
  localparam int NUM_BANKS = 2;
  localparam int REG_WORDS = 3;
  localparam int CB_START  = 0;
  localparam int CB_PROG   = 1;
  localparam int CB_IRQ    = 3;
  localparam int GIE_BIT   = 31;

  typedef enum logic [1:0] {RG_LEN = 2'd0, RG_GIE = 2'd1, RG_CTRL = 2'd2, RG_NONE = 2'd3} reg_sel_e;

  typedef enum logic [2:0] {
    E_IDLE, E_ANNOUNCE, E_FETCH, E_LATCH, E_DRIVE, E_FINISH
  } eng_state_e;

  // frame length actually sent: requested length capped at buffer size
  function automatic int unsigned clamp_len(int unsigned len, int unsigned cap);
    return (len > cap) ? cap : len;
  endfunction

  // byte lane k of a little-endian buffer word
  function automatic logic [7:0] lane_byte(logic [31:0] w, logic [1:0] lane);
    return w[8*lane +: 8];
  endfunction
endpackage

// File: rtl/tx_store.sv
module tx_store #(
  parameter int WORDS = 505,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/tx_regs.sv
module tx_regs
  import mac_tx_pkg::*;
#(
  parameter int BANK_BIT  = 11,
  parameter int BUF_BYTES = 2020,
  parameter int LEN_W     = 11,
  parameter int AW        = 9
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bus_sel,
  input  logic                             bus_we,
  input  logic [BANK_BIT:0]                bus_addr,
  input  logic [31:0]                      bus_wdata,
  output logic [31:0]                      bus_rdata,
  output logic [NUM_BANKS-1:0]             mem_we,
  output logic [AW-1:0]                    mem_waddr,
  output logic [NUM_BANKS-1:0]             req_start,
  output logic [NUM_BANKS-1:0]             req_prog,
  output logic [NUM_BANKS-1:0][LEN_W-1:0]  len_out,
  input  logic                             op_done,
  input  logic                             op_bank,
  output logic                             irq
);
  localparam logic [BANK_BIT-1:0] REG_BASE_L = BANK_BIT'((1 << BANK_BIT) - 4*REG_WORDS);

  logic [NUM_BANKS-1:0][31:0]      ctrl_q;
  logic [NUM_BANKS-1:0]            gie_q;
  logic [NUM_BANKS-1:0][LEN_W-1:0] len_q;
  logic [31:0] rdata_q;
  logic        irq_q;

  logic [BANK_BIT-1:0] off, rel;
  logic     bank, aligned, is_reg, is_mem, wr, rd;
  reg_sel_e rsel;

  always_comb begin
    off     = bus_addr[BANK_BIT-1:0];
    bank    = bus_addr[BANK_BIT];
    aligned = (bus_addr[1:0] == 2'b00);
    rel     = off - REG_BASE_L;
    is_reg  = aligned && (off >= REG_BASE_L);
    is_mem  = aligned && (32'(off) < BUF_BYTES);
    rsel    = is_reg ? reg_sel_e'(2'(rel >> 2)) : RG_NONE;
    wr      = bus_sel && bus_we;
    rd      = bus_sel && !bus_we;
  end

  assign mem_waddr = AW'(off >> 2);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign mem_we[b]    = wr && is_mem && (bank == b[0]);
    assign req_start[b] = ctrl_q[b][CB_START];
    assign req_prog[b]  = ctrl_q[b][CB_PROG];
    assign len_out[b]   = len_q[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      gie_q   <= '0;
      len_q   <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (wr && (bank == b[0])) begin
          case (rsel)
            RG_LEN:  len_q[b] <= bus_wdata[LEN_W-1:0];
            RG_GIE:  gie_q[b] <= bus_wdata[GIE_BIT];
            RG_CTRL: if (!ctrl_q[b][CB_START])
                       ctrl_q[b] <= bus_wdata[CB_START] ? bus_wdata : (bus_wdata & ~32'h3);
            default: ;
          endcase
        end
        if (op_done && (op_bank == b[0])) begin
          ctrl_q[b][CB_START] <= 1'b0;
          ctrl_q[b][CB_PROG]  <= 1'b0;
        end
      end
      irq_q <= op_done && ctrl_q[op_bank][CB_IRQ] && gie_q[0];
      if (rd) begin
        case (rsel)
          RG_LEN:  rdata_q <= 32'(len_q[bank]);
          RG_GIE:  rdata_q <= {gie_q[bank], 31'b0};
          RG_CTRL: rdata_q <= ctrl_q[bank];
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/tx_engine.sv
module tx_engine
  import mac_tx_pkg::*;
#(
  parameter int          BUF_BYTES   = 2020,
  parameter int          LEN_W       = 11,
  parameter int          AW          = 9,
  parameter logic [47:0] STATION_RST = 48'h0200_0000_0001
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_BANKS-1:0]            req_start,
  input  logic [NUM_BANKS-1:0]            req_prog,
  input  logic [NUM_BANKS-1:0][LEN_W-1:0] len_in,
  output logic                            rd_en,
  output logic [AW-1:0]                   rd_addr,
  output logic                            cur_bank,
  input  logic [31:0]                     rd_data,
  output logic                            fo_start,
  output logic [LEN_W-1:0]                fo_len,
  output logic                            fo_valid,
  input  logic                            fo_ready,
  output logic [7:0]                      fo_data,
  output logic                            fo_last,
  output logic                            fo_done,
  output logic [47:0]                     station_addr,
  output logic                            op_done,
  output logic                            op_prog
);
  eng_state_e       st;
  logic             bank_q, prog_q, pick;
  logic [LEN_W-1:0] total, cnt;
  logic [31:0]      word_q, lo_q;
  logic [47:0]      station_q;
  logic             at_end;

  assign pick   = req_start[0] ? 1'b0 : 1'b1;
  assign at_end = (cnt == total - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= E_IDLE;
      bank_q    <= 1'b0;
      prog_q    <= 1'b0;
      total     <= '0;
      cnt       <= '0;
      word_q    <= '0;
      lo_q      <= '0;
      station_q <= STATION_RST;
    end else begin
      case (st)
        E_IDLE: if (|req_start) begin
          bank_q <= pick;
          prog_q <= req_prog[pick];
          cnt    <= '0;
          total  <= req_prog[pick] ? LEN_W'(6)
                    : LEN_W'(clamp_len(32'(len_in[pick]), BUF_BYTES));
          st     <= req_prog[pick] ? E_FETCH : E_ANNOUNCE;
        end
        E_ANNOUNCE: st <= (total == '0) ? E_FINISH : E_FETCH;
        E_FETCH:    st <= E_LATCH;
        E_LATCH: begin
          word_q <= rd_data;
          if (prog_q) begin
            if (cnt == '0) begin
              lo_q <= rd_data;
              cnt  <= LEN_W'(4);
              st   <= E_FETCH;
            end else begin
              st <= E_FINISH;
            end
          end else begin
            st <= E_DRIVE;
          end
        end
        E_DRIVE: if (fo_ready) begin
          cnt <= cnt + LEN_W'(1);
          if (at_end)                st <= E_FINISH;
          else if (cnt[1:0] == 2'b11) st <= E_FETCH;
        end
        E_FINISH: begin
          if (prog_q)
            station_q <= {lane_byte(lo_q, 2'd0), lane_byte(lo_q, 2'd1),
                          lane_byte(lo_q, 2'd2), lane_byte(lo_q, 2'd3),
                          lane_byte(word_q, 2'd0), lane_byte(word_q, 2'd1)};
          st <= E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  assign rd_en        = (st == E_FETCH);
  assign rd_addr      = AW'(cnt >> 2);
  assign cur_bank     = bank_q;
  assign fo_start     = (st == E_ANNOUNCE);
  assign fo_len       = total;
  assign fo_valid     = (st == E_DRIVE);
  assign fo_data      = lane_byte(word_q, cnt[1:0]);
  assign fo_last      = fo_valid && at_end;
  assign op_done      = (st == E_FINISH);
  assign op_prog      = prog_q;
  assign fo_done      = op_done && !prog_q;
  assign station_addr = station_q;
endmodule

// File: rtl/mac_tx_cmd.sv
module mac_tx_cmd
  import mac_tx_pkg::*;
#(
  parameter int          BANK_BIT    = 11,
  parameter int          BUF_BYTES   = 2020,
  parameter logic [47:0] STATION_RST = 48'h0200_0000_0001,
  localparam int         ADDR_W      = BANK_BIT + 1,
  localparam int         AW          = BANK_BIT - 2,
  localparam int         WORDS       = (BUF_BYTES + 3) / 4,
  localparam int         LEN_W       = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              fo_start,
  output logic [LEN_W-1:0]  fo_len,
  output logic              fo_valid,
  input  logic              fo_ready,
  output logic [7:0]        fo_data,
  output logic              fo_last,
  output logic              fo_done,
  output logic [47:0]       station_addr,
  output logic              irq
);
  logic [NUM_BANKS-1:0]            mem_we, req_start, req_prog;
  logic [NUM_BANKS-1:0][LEN_W-1:0] len_vec;
  logic [NUM_BANKS-1:0][31:0]      rd_word;
  logic [AW-1:0] mem_waddr, rd_addr;
  logic          rd_en, cur_bank, op_done, op_prog;

  tx_regs #(.BANK_BIT(BANK_BIT), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .req_start(req_start), .req_prog(req_prog), .len_out(len_vec),
    .op_done(op_done), .op_bank(cur_bank), .irq(irq)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_store
    tx_store #(.WORDS(WORDS), .AW(AW)) u_store (
      .clk(clk), .wr_en(mem_we[b]), .wr_addr(mem_waddr), .wr_data(bus_wdata),
      .rd_en(rd_en && (cur_bank == b[0])), .rd_addr(rd_addr), .rd_data(rd_word[b])
    );
  end

  tx_engine #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W), .AW(AW), .STATION_RST(STATION_RST)) u_eng (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_prog(req_prog), .len_in(len_vec),
    .rd_en(rd_en), .rd_addr(rd_addr), .cur_bank(cur_bank), .rd_data(rd_word[cur_bank]),
    .fo_start(fo_start), .fo_len(fo_len), .fo_valid(fo_valid), .fo_ready(fo_ready),
    .fo_data(fo_data), .fo_last(fo_last), .fo_done(fo_done), .station_addr(station_addr),
    .op_done(op_done), .op_prog(op_prog)
  );
endmodule

// File: rtl/mac_tx_cmd_chk.sv
module mac_tx_cmd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic        op_done,
  input logic        op_prog,
  input logic        fo_start,
  input logic        fo_valid,
  input logic        fo_ready,
  input logic [7:0]  fo_data,
  input logic [47:0] station_addr
);
  // R9: interrupt is a single-cycle pulse
  a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  // R9: interrupt only follows a completion
  a_r9_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n) irq |-> $past(op_done));
  // R11: stalled byte holds
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fo_valid && !fo_ready |=> fo_valid && $stable(fo_data));
  // R4: announce never overlaps a byte
  a_r4_start_alone: assert property (@(posedge clk) disable iff (!rst_n) fo_start |-> !fo_valid);
  // R5: station address moves only at the end of a program operation
  a_r5_station_only_prog: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(station_addr) |-> $past(op_done && op_prog));
endmodule

bind mac_tx_cmd mac_tx_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .op_done(op_done), .op_prog(op_prog),
  .fo_start(fo_start), .fo_valid(fo_valid), .fo_ready(fo_ready), .fo_data(fo_data),
  .station_addr(station_addr)
);

// File: tb/tb_mac_tx_cmd.sv
module tb_mac_tx_cmd;
  localparam int BUFB = 2020;
  localparam logic [11:0] LEN0 = 12'h7F4, GIE0 = 12'h7F8, CTL0 = 12'h7FC;
  localparam logic [11:0] B1 = 12'h800;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0, fo_ready = 1;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic fo_start, fo_valid, fo_last, fo_done, irq;
  logic [10:0] fo_len;
  logic [7:0] fo_data;
  logic [47:0] station_addr;

  mac_tx_cmd dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, ready_mode = 0;
  int starts = 0, dones = 0, irqs = 0, rxn = 0, lasts = 0;
  int last_len = 0;
  logic [7:0] rx [4096];
  logic [7:0] model [2][2048];

  always @(posedge clk) if (rst_n) begin
    if (fo_start) begin starts++; last_len = int'(fo_len); end
    if (fo_valid && fo_ready) begin rx[rxn] = fo_data; rxn++; if (fo_last) lasts++; end
    if (fo_done) dones++;
    if (irq) irqs++;
  end

  always @(negedge clk) begin
    cyc++;
    fo_ready = (ready_mode == 0) || (ready_mode == 1 && (cyc[0] ^ cyc[2]));
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run did not end, act=%0d exp<=150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
    if (int'(a[10:0]) < BUFB)
      for (int k = 0; k < 4; k++) model[a[11]][int'(a[10:0]) + k] = d[8*k +: 8];
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic wait_idle(logic [11:0] bank);
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      bus_read(bank | CTL0, v);
      if (!v[0]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic fill(int bank, int nwords, int seed);
    for (int w = 0; w < nwords; w++)
      bus_write(12'(bank * 2048 + 4 * w),
                {8'(seed + 4*w + 3), 8'(seed + 4*w + 2), 8'(seed + 4*w + 1), 8'(seed + 4*w)});
  endtask

  task automatic cmp_frame(string tag, int bank, int at, int n);
    int bad = -1;
    for (int i = 0; i < n; i++) if (bad < 0 && rx[at + i] !== model[bank][i]) bad = i;
    if (bad < 0) chk(tag, 0, 0);
    else chk(tag, longint'(rx[at + bad]), longint'(model[bank][bad]));
  endtask

  task automatic t_reset;
    logic [31:0] v;
    bus_read(LEN0, v);  chk("R1 len reset", v, 0);
    bus_read(CTL0, v);  chk("R1 ctrl reset", v, 0);
    chk("R1 station reset", station_addr, 48'h0200_0000_0001);
    chk("R1 outputs idle", {irq, fo_valid, fo_start, fo_done}, 0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    bus_write(B1 | GIE0, 32'hFFFF_FFFF); bus_read(B1 | GIE0, v); chk("R2 gie bit31 only", v, 32'h8000_0000);
    bus_write(B1 | LEN0, 32'h0000_FFFF); bus_read(B1 | LEN0, v); chk("R2 len width", v, 32'h7FF);
    bus_read(LEN0, v);       chk("R2 bank0 untouched", v, 0);
    bus_read(12'h7E4, v);    chk("R2 reserved reads 0", v, 0);
    bus_read(12'h010, v);    chk("R2 buffer area reads 0", v, 0);
    bus_write(B1 | GIE0, 0);
  endtask

  task automatic t_send_basic;
    int r0 = rxn, s0 = starts, d0 = dones, i0 = irqs, l0 = lasts;
    bus_write(LEN0, 16); bus_write(CTL0, 32'h1);
    wait_idle(0);
    chk("R4 one start", starts - s0, 1);
    chk("R4 fo_len", last_len, 16);
    chk("R4 byte count", rxn - r0, 16);
    chk("R4 one last flag", lasts - l0, 1);
    chk("R4 one done", dones - d0, 1);
    cmp_frame("R3 R4 bytes in order", 0, r0, 16);
    chk("R9 no irq when bit3 clear", irqs - i0, 0);
  endtask

  task automatic t_backpressure;
    int r0 = rxn;
    ready_mode = 1;
    bus_write(B1 | LEN0, 7); bus_write(B1 | CTL0, 32'h1);
    wait_idle(B1);
    ready_mode = 0;
    chk("R11 count under stall", rxn - r0, 7);
    cmp_frame("R11 bytes under stall", 1, r0, 7);
  endtask

  task automatic t_busy;
    logic [31:0] v;
    int r0 = rxn, i0 = irqs, s0 = starts;
    bus_write(GIE0, 32'h8000_0000);
    ready_mode = 2;
    bus_write(LEN0, 5); bus_write(CTL0, 32'hF9);
    repeat (6) @(negedge clk);
    bus_read(CTL0, v); chk("R6 busy bits read as written", v, 32'hF9);
    bus_write(CTL0, 32'h0);
    bus_read(CTL0, v); chk("R8 write while busy ignored", v, 32'hF9);
    ready_mode = 0;
    wait_idle(0);
    bus_read(CTL0, v); chk("R6 run bits clear, rest kept", v, 32'hF8);
    chk("R8 no extra start", starts - s0, 1);
    cmp_frame("R6 frame while busy", 0, r0, 5);
    chk("R9 irq with bit3 and bank0 enable", irqs - i0, 1);
  endtask

  task automatic t_irq_gate;
    int i0 = irqs;
    bus_write(GIE0, 0); bus_write(B1 | GIE0, 32'h8000_0000);
    bus_write(B1 | LEN0, 3); bus_write(B1 | CTL0, 32'h9);
    wait_idle(B1);
    chk("R9 bank1 enable has no effect", irqs - i0, 0);
    bus_write(GIE0, 32'h8000_0000); bus_write(B1 | GIE0, 0);
    bus_write(B1 | CTL0, 32'h9);
    wait_idle(B1);
    chk("R9 bank1 irq gated by bank0 enable", irqs - i0, 1);
    bus_write(GIE0, 0);
  endtask

  task automatic t_queue;
    int r0 = rxn, s0 = starts;
    ready_mode = 2;
    bus_write(LEN0, 8); bus_write(CTL0, 32'h1);
    bus_write(B1 | LEN0, 4); bus_write(B1 | CTL0, 32'h1);
    ready_mode = 0;
    wait_idle(0); wait_idle(B1);
    chk("R10 both frames sent", starts - s0, 2);
    chk("R10 total bytes", rxn - r0, 12);
    cmp_frame("R10 running frame first", 0, r0, 8);
    cmp_frame("R10 queued frame second", 1, r0 + 8, 4);
  endtask

  task automatic t_clamp_zero;
    int r0 = rxn, d0 = dones;
    bus_write(LEN0, 32'h7FF); bus_write(CTL0, 32'h1);
    wait_idle(0);
    chk("R4 length capped", last_len, BUFB);
    chk("R4 capped byte count", rxn - r0, BUFB);
    cmp_frame("R3 full buffer bytes", 0, r0, BUFB);
    r0 = rxn;
    bus_write(B1 | LEN0, 0); bus_write(B1 | CTL0, 32'h1);
    wait_idle(B1);
    chk("R4 zero length fo_len", last_len, 0);
    chk("R4 zero length no bytes", rxn - r0, 0);
    chk("R4 zero length done", dones - d0, 2);
  endtask

  task automatic t_program;
    int s0 = starts, r0 = rxn;
    logic [31:0] v;
    bus_write(B1 | 12'h000, 32'h4433_2211); bus_write(B1 | 12'h004, 32'h0000_6655);
    bus_write(B1 | CTL0, 32'h3);
    wait_idle(B1);
    chk("R5 station address", station_addr, 48'h1122_3344_5566);
    chk("R5 no frame", (starts - s0) + (rxn - r0), 0);
    bus_read(B1 | CTL0, v); chk("R6 program bits cleared", v, 0);
  endtask

  task automatic t_no_start;
    int s0 = starts, d0 = dones;
    logic [31:0] v;
    bus_write(B1 | CTL0, 32'hA);
    repeat (20) @(negedge clk);
    bus_read(B1 | CTL0, v); chk("R7 stored with bits 1:0 clear", v, 32'h8);
    chk("R7 nothing started", (starts - s0) + (dones - d0), 0);
    chk("R7 station unchanged", station_addr, 48'h1122_3344_5566);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_map;
    fill(0, (BUFB + 3) / 4, 8'h10);
    fill(1, 16, 8'hA0);
    t_send_basic;
    t_backpressure;
    t_busy;
    t_irq_gate;
    t_queue;
    t_clamp_zero;
    t_program;
    t_no_start;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule